// File: doc/BRIEF.md
# Programmable I/O Cycle Sequencer

This block produces the timing of one access on a slow 16-bit peripheral bus. The bus runs from a 16 MHz clock. A CPU-side requester presents an address and a direction with a one-clock request. The sequencer decodes the address into one of three address groups. It looks up the cycle type configured for that group. It then drives an active-low chip select and an active-low read or write strobe for the number of clocks that type calls for. When the access ends, it pulses an acknowledge.

Each group has its own type field in a small control register. That register is loaded through a whole-word write port. There are four types, each a fixed number of clocks. Two groups sit in the main I/O space and may use any type. The third group is the extended region, and it can only run the two slower types. A peripheral can lengthen any access by holding READY low at the sample point, one clock before the planned end. Chip select and the strobe then stay low until READY is seen high again.

Top module: `io_cycle_seq`

## Requirements
- R1: After reset, chip select, read strobe and write strobe are high, acknowledge is low, and every group's type field holds D (code 3).
- R2: Address bits [15:14] pick the group. 00 selects group 0, 01 selects group 1, and 10 or 11 selects group 2, the extended group.
- R3: A write with cfg_we high loads cfg_wdata into the type register. Group g uses bits [2g+1:2g]. Codes 0, 1, 2 and 3 select types A, B, C and D. Without a stretch, chip select stays low for 3, 4, 5 or 6 clocks respectively.
- R4: Group 2 supports only types C and D. Bit 1 of its field is ignored, and bit 0 selects C (0) or D (1).
- R5: Chip select falls one clock after a request is accepted. The strobe for the direction falls one clock after chip select and rises together with it. The strobe is rd_n when req_write=0 and wr_n when req_write=1, and the other strobe stays high.
- R6: READY is sampled at the rising edge that ends the second-to-last clock of the access. Each consecutive low sample from that point adds one clock, and chip select and the strobe stay low throughout.
- R7: Stretching works the same way for every cycle type and every group.
- R8: Acknowledge is high for exactly one clock. That clock immediately follows the last clock in which chip select was low.
- R9: A request is accepted only while the sequencer is idle. A request during an access or during its acknowledge clock starts nothing.
- R10: The cycle length and direction are fixed when the request is accepted. A register write during an access does not change that access.
- R11: READY low in clocks before the sample point does not lengthen the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-clock access request |
| req_addr | input | 16 | Access address; top bits select the group |
| req_write | input | 1 | 1 = write access, 0 = read access |
| ack | output | 1 | One-clock completion pulse |
| cfg_we | input | 1 | Type register write enable |
| cfg_wdata | input | 6 | New type register value, 2 bits per group |
| ready | input | 1 | Peripheral ready; low at the sample point stretches |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Some rules are checked by assertions on every cycle. Both strobes are never low at once. No strobe is low while chip select is high. Acknowledge lasts one clock and directly follows chip select. Chip select only falls after a request seen while idle. A low READY at the sample point keeps the bus held. The bench must show the rest. That covers the exact clock counts per type and group, the extended group's clamp, stretch lengths, early READY lows that have no effect, and requests and register writes arriving in mid-access.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;
  typedef enum logic [1:0] {
    CYC_A = 2'd0,
    CYC_B = 2'd1,
    CYC_C = 2'd2,
    CYC_D = 2'd3
  } cyc_type_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  localparam int unsigned CNT_W   = 3;
  localparam int unsigned MIN_LEN = 3;

  function automatic logic [CNT_W-1:0] cyc_len(input cyc_type_e t);
    return CNT_W'(MIN_LEN) + CNT_W'(t);
  endfunction
endpackage

// File: rtl/io_seq_grp_dec.sv
module io_seq_grp_dec #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_GRP = 3,
  localparam int unsigned GRP_W  = $clog2(NUM_GRP)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [GRP_W-1:0]  grp_o
);
  logic [GRP_W-1:0] sel;
  logic             unused_low;

  assign sel        = addr_i[ADDR_W-1 -: GRP_W];
  assign unused_low = ^addr_i[ADDR_W-GRP_W-1:0];

  // All codes at or above the last group fold into the extended group
  always_comb begin
    if (sel >= GRP_W'(NUM_GRP-1)) grp_o = GRP_W'(NUM_GRP-1);
    else                          grp_o = sel;
  end
endmodule

// File: rtl/io_seq_cfg.sv
module io_seq_cfg
  import io_seq_pkg::*;
#(
  parameter int unsigned NUM_GRP = 3,
  localparam int unsigned GRP_W  = $clog2(NUM_GRP),
  localparam int unsigned CFG_W  = 2*NUM_GRP,
  localparam int unsigned SLOTS  = 2**GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic [GRP_W-1:0] grp_i,
  output cyc_type_e        typ_o
);
  logic [CFG_W-1:0] cfg_q, cfg_d;
  cyc_type_e        typ_eff [SLOTS];

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) cfg_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '1;
    else if (we_i) cfg_q <= cfg_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_GRP-1) begin : g_full
      assign typ_eff[g] = cyc_type_e'(cfg_q[2*g +: 2]);
    end else if (g == NUM_GRP-1) begin : g_ext
      // extended region: only the two slow types
      assign typ_eff[g] = cyc_type_e'({1'b1, cfg_q[2*g]});
    end else begin : g_pad
      assign typ_eff[g] = CYC_D;
    end
  end

  assign typ_o = typ_eff[grp_i];

  // R4
  ext_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_i == GRP_W'(NUM_GRP-1)) |-> (typ_o == CYC_C || typ_o == CYC_D));
endmodule

// File: rtl/io_seq_fsm.sv
module io_seq_fsm
  import io_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_i,
  input  logic      write_i,
  input  cyc_type_e typ_i,
  input  logic      ready_i,
  output logic      ack_o,
  output logic      cs_n_o,
  output logic      rd_n_o,
  output logic      wr_n_o
);
  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q;
  logic             dir_q;
  logic             load;
  logic             strobe;

  assign load = (st_q == ST_IDLE) && req_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        st_d  = ST_RUN;
        cnt_d = CNT_W'(1);
      end
      ST_RUN: begin
        if (cnt_q == last_q)                            st_d = ST_DONE;
        else if (cnt_q == last_q - CNT_W'(1) && !ready_i) st_d = ST_HOLD;
        else                                            cnt_d = cnt_q + CNT_W'(1);
      end
      ST_HOLD: if (ready_i) begin
        st_d  = ST_RUN;
        cnt_d = last_q;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= CNT_W'(MIN_LEN);
      dir_q  <= 1'b0;
    end else if (load) begin
      last_q <= cyc_len(typ_i);
      dir_q  <= write_i;
    end
  end

  assign strobe = (st_q == ST_HOLD) || (st_q == ST_RUN && cnt_q >= CNT_W'(2));
  assign cs_n_o = !(st_q == ST_RUN || st_q == ST_HOLD);
  assign rd_n_o = !(strobe && !dir_q);
  assign wr_n_o = !(strobe && dir_q);
  assign ack_o  = (st_q == ST_DONE);

  // R5
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> (rd_n_o && wr_n_o));
  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  // R8
  ack_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(!cs_n_o));
  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && !ack_o && !req_i) |=> cs_n_o);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !rd_n_o && !ready_i && cnt_q == last_q - CNT_W'(1)) |=> (!cs_n_o && !rd_n_o));
  // R10
  len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o)) |-> $stable(last_q));
endmodule

// File: rtl/io_cycle_seq.sv
module io_cycle_seq
  import io_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_GRP = 3,
  localparam int unsigned GRP_W  = $clog2(NUM_GRP),
  localparam int unsigned CFG_W  = 2*NUM_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              ack,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              ready,
  output logic              cs_n,
  output logic              rd_n,
  output logic              wr_n
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [GRP_W-1:0] grp;
  cyc_type_e        typ;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  io_seq_grp_dec #(.ADDR_W(ADDR_W), .NUM_GRP(NUM_GRP)) u_dec (
    .addr_i (req_addr),
    .grp_o  (grp)
  );

  io_seq_cfg #(.NUM_GRP(NUM_GRP)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_i    (cfg_we),
    .wdata_i (cfg_wdata),
    .grp_i   (grp),
    .typ_o   (typ)
  );

  io_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req_i   (req_valid),
    .write_i (req_write),
    .typ_i   (typ),
    .ready_i (ready),
    .ack_o   (ack),
    .cs_n_o  (cs_n),
    .rd_n_o  (rd_n),
    .wr_n_o  (wr_n)
  );
endmodule

// File: tb/io_cycle_seq_tb.sv
module io_cycle_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, cfg_we, ready;
  logic [15:0] req_addr;
  logic [5:0]  cfg_wdata;
  logic        ack, cs_n, rd_n, wr_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [5:0] cfg_m = 6'h3f;

  always #10 clk = ~clk;

  io_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .ack(ack), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ready(ready), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [15:0] a, input logic [5:0] c);
    int g = (a[15:14] >= 2) ? 2 : int'(a[15:14]);
    logic [1:0] f = c[2*g +: 2];
    if (g == 2) f[1] = 1'b1;   // R4 clamp
    return 3 + int'(f);
  endfunction

  task automatic cfg_write(input logic [5:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    cfg_m = d;
  endtask

  task automatic access(input logic [15:0] a, input bit w, input int wt,
                        input bit early, input bit busy, input bit cfgmid,
                        input logic [5:0] nc);
    int n = exp_len(a, cfg_m);
    int k = 1;
    @(negedge clk); req_valid = 1'b1; req_addr = a; req_write = w; ready = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    chk(cs_n == 1'b0, "R5 cs falls", int'(cs_n), 0);
    forever begin
      chk(rd_n == !(k >= 2 && !w) && wr_n == !(k >= 2 && w), "R5 strobe",
          int'({rd_n, wr_n}), int'({!(k >= 2 && !w), !(k >= 2 && w)}));
      if (early) ready = !(k < n-1);
      else       ready = !(k >= n-1 && k < n-1+wt);
      if (busy && k == 2) begin req_valid = 1'b1; req_addr = ~a; req_write = !w; end
      if (k == 3) req_valid = 1'b0;
      if (cfgmid && k == 1) begin cfg_we = 1'b1; cfg_wdata = nc; end
      if (k == 2) cfg_we = 1'b0;
      @(negedge clk);
      if (cs_n || k > 40) break;
      k++;
    end
    req_valid = 1'b0; cfg_we = 1'b0; ready = 1'b1;
    if (cfgmid) cfg_m = nc;
    // R6 R7 R10 R11: total low clocks
    chk(k == n + (early ? 0 : wt), wt > 0 ? "R6/R7 stretch" : (early ? "R11 early low" : "R3 length"),
        k, n + (early ? 0 : wt));
    chk(ack == 1'b1 && rd_n && wr_n, "R8 ack", int'(ack), 1);
    if (busy) begin req_valid = 1'b1; req_addr = a; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(ack == 1'b0, "R8 single pulse", int'(ack), 0);
    if (busy) begin
      chk(cs_n == 1'b1, "R9 busy request dropped", int'(cs_n), 1);
      @(negedge clk);
      chk(cs_n == 1'b1, "R9 no late start", int'(cs_n), 1);
    end
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk) cyc++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    cfg_we = 1'b0; cfg_wdata = '0; ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(cs_n && rd_n && wr_n && !ack, "R1 reset outputs", int'({cs_n, rd_n, wr_n, ack}), 14);
    access(16'h0010, 1'b0, 0, 1'b0, 1'b0, 1'b0, 6'h0); // R1 default D
    access(16'hc000, 1'b1, 0, 1'b0, 1'b0, 1'b0, 6'h0); // R1 R2 ext default D
    cfg_write(6'b10_01_00);                           // R3: g0=A g1=B g2=C
    access(16'h0123, 1'b0, 0, 1'b0, 1'b0, 1'b0, 6'h0); // R2 group 0 -> 3
    access(16'h4123, 1'b1, 0, 1'b0, 1'b0, 1'b0, 6'h0); // R2 group 1 -> 4
    access(16'h8000, 1'b0, 0, 1'b0, 1'b0, 1'b0, 6'h0); // R2 group 2 -> 5
    cfg_write(6'b00_11_10);                           // R4: ext field 00 -> C
    access(16'hffff, 1'b1, 0, 1'b0, 1'b0, 1'b0, 6'h0);
    access(16'h3fff, 1'b0, 0, 1'b0, 1'b0, 1'b0, 6'h0);
    cfg_write(6'b01_00_00);                           // R4: ext field 01 -> D
    access(16'h9000, 1'b0, 0, 1'b0, 1'b0, 1'b0, 6'h0);
    access(16'h0000, 1'b1, 2, 1'b0, 1'b0, 1'b0, 6'h0); // R6 type A stretch
    access(16'h4000, 1'b0, 0, 1'b1, 1'b0, 1'b0, 6'h0); // R11 early low
    access(16'h0000, 1'b0, 1, 1'b0, 1'b1, 1'b0, 6'h0); // R9 busy request
    access(16'h0000, 1'b1, 0, 1'b0, 1'b0, 1'b1, 6'h3f); // R10 mid write to D
    access(16'h0000, 1'b0, 0, 1'b0, 1'b0, 1'b0, 6'h0); // R10 new type now 6
    for (int i = 0; i < 40; i++) begin                 // R7 random mix
      if ($urandom_range(3) == 0) cfg_write(6'($urandom));
      access(16'($urandom), 1'($urandom), int'($urandom_range(3)),
             $urandom_range(4) == 0, $urandom_range(3) == 0,
             $urandom_range(4) == 0, 6'($urandom));
    end
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule